// File: doc/BRIEF.md
# Two-Policy Interrupt Priority Arbiter

This block chooses which device interrupt a single processor serves next. Every device line has a fixed priority level. A run-time mode input selects one of two policies. In the non-preemptive policy, waiting requests are ordered by priority, but a handler that is running always finishes first. In the preemptive policy, a handler can be interrupted only by a request of strictly higher level. The preempted level is kept on a small stack and comes back when the nested handler signals completion.

Requests are captured as pending bits. A grant is a one-cycle acknowledge together with the winning device index. The active level leaves the block as the upper bits of the program counter: the most significant bit is the kernel flag, and below it are the level bits. The processor strobes `done` when the current handler returns.

Top module: `irq_prio_arb`

## Requirements
- R1: A synchronous active-high `rst` clears all pending requests, empties the level stack, drives `ack` low and sets `pcHigh` to 0. A request held during reset is not served afterwards.
- R2: A rising edge that samples `req[d]` high marks device d pending until it is granted. Holding or re-asserting `req[d]` while d is pending produces no second grant. A request high at the same edge that grants d is absorbed by that grant.
- R3: Device index d has priority level d+1, and level 0 is the user level. Among pending devices that may be granted, the highest index wins.
- R4: A grant is a single-cycle `ack` with `vector` equal to the device index. From idle, `ack` is high after the second rising edge that follows the request being sampled. In the same cycle, `pcHigh` shows the new level.
- R5: With `strongMode` low, no grant is made while a handler is active. Pending requests are served once the processor is idle again.
- R6: With `strongMode` high, a pending request preempts the running handler only if its level is strictly greater than the current level. Lower requests stay pending.
- R7: A request at the same level as the running handler never preempts it, in either mode. It is served after that handler completes.
- R8: A `done` strobe while a handler is active restores the level that was running before it (user level 0 if none). No grant is made at that edge. A pending request that is eligible is then granted one edge later.
- R9: `pcHigh` is {kernel, level}: the kernel bit is 1 exactly while a handler is active, and `pcHigh` is 0 when idle.
- R10: A `done` strobe while no handler is active has no effect on the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strongMode | input | 1 | 1 = preemptive nested policy, 0 = non-preemptive |
| req | input | NUM_DEV | Device interrupt request lines, index d at level d+1 |
| done | input | 1 | Current handler has returned |
| ack | output | 1 | One-cycle grant pulse |
| vector | output | $clog2(NUM_DEV) | Index of the granted device (held between grants) |
| pcHigh | output | LVL_W+1 | Upper PC bits: kernel flag above the active level |

## Verification
If a pending bit is wrongly kept, an extra `ack` appears right after the handler of that device finishes. If a pending bit is wrongly lost, an expected `ack` never arrives. A corrupted stack entry shows on `pcHigh` at the very edge that takes `done`, as the wrong resumed level. A wrong policy decision shows within one cycle of the offending request, as an `ack` that should not occur or a missing preemption. The bench model predicts `ack`, `vector` and `pcHigh` for every cycle, so any such divergence is caught at the first cycle it reaches the ports.

// File: rtl/irq_prio_arb_pkg.sv
package irq_prio_arb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic push;   // grant: save level, enter new handler
    logic pop;    // handler returned: restore saved level
  } arbStrobe_t;
endpackage

// File: rtl/irq_prio_arb_ctrl.sv
module irq_prio_arb_ctrl
  import irq_prio_arb_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strongMode,
  input  logic [NUM_DEV-1:0] req,
  input  logic               done,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic               active,
  output arbStrobe_t         strobe,
  output logic [IDX_W-1:0]   grantIdx
);
  logic [NUM_DEV-1:0] pending;
  logic [NUM_DEV-1:0] grantMask;
  logic [IDX_W-1:0]   best;
  logic               found;
  logic [LVL_W-1:0]   bestLevel;
  logic               popNow;
  logic               canGrant;

  // highest index among pending wins
  always_comb begin
    best  = '0;
    found = 1'b0;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (pending[d]) begin
        best  = IDX_W'(d);
        found = 1'b1;
      end
    end
  end

  assign bestLevel = LVL_W'(best) + LVL_W'(1);
  assign popNow    = done && active;
  assign canGrant  = found && !popNow && (bestLevel > curLevel) &&
                     (strongMode || !active);
  assign grantMask = canGrant ? (NUM_DEV'(1) << best) : '0;

  always_comb begin
    strobe.push = canGrant;
    strobe.pop  = popNow;
  end
  assign grantIdx = best;

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else     pending <= (pending | req) & ~grantMask;
  end
endmodule

// File: rtl/irq_prio_arb_dp.sv
module irq_prio_arb_dp
  import irq_prio_arb_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_DEV),
  localparam int SP_W   = $clog2(NUM_DEV + 1),
  localparam int STK_D  = 1 << SP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  arbStrobe_t       strobe,
  input  logic [IDX_W-1:0] grantIdx,
  output logic [LVL_W-1:0] curLevel,
  output logic             active,
  output logic             ack,
  output logic [IDX_W-1:0] vector
);
  logic [LVL_W-1:0] stack [STK_D];
  logic [SP_W-1:0]  sp;

  assign active = (sp != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp       <= '0;
      curLevel <= '0;
      ack      <= 1'b0;
      vector   <= '0;
      for (int i = 0; i < STK_D; i++) stack[i] <= '0;
    end else begin
      ack <= 1'b0;
      if (strobe.pop) begin
        curLevel <= stack[sp - SP_W'(1)];
        sp       <= sp - SP_W'(1);
      end else if (strobe.push) begin
        stack[sp] <= curLevel;
        sp        <= sp + SP_W'(1);
        curLevel  <= LVL_W'(grantIdx) + LVL_W'(1);
        ack       <= 1'b1;
        vector    <= grantIdx;
      end
    end
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_arb_pkg::*;
#(
  parameter int NUM_DEV = 3,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strongMode,
  input  logic [NUM_DEV-1:0] req,
  input  logic               done,
  output logic               ack,
  output logic [IDX_W-1:0]   vector,
  output logic [LVL_W:0]     pcHigh
);
  arbStrobe_t       strobe;
  logic [IDX_W-1:0] grantIdx;
  logic [LVL_W-1:0] curLevel;
  logic             active;

  irq_prio_arb_ctrl #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst(rst), .strongMode(strongMode), .req(req), .done(done),
    .curLevel(curLevel), .active(active), .strobe(strobe), .grantIdx(grantIdx)
  );

  irq_prio_arb_dp #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .grantIdx(grantIdx),
    .curLevel(curLevel), .active(active), .ack(ack), .vector(vector)
  );

  assign pcHigh = {active, curLevel};
endmodule

// File: rtl/irq_prio_arb_checker.sv
module irq_prio_arb_checker #(
  parameter int NUM_DEV = 3,
  parameter int LVL_W   = 3,
  localparam int IDX_W  = $clog2(NUM_DEV)
) (
  input logic             clk,
  input logic             rst,
  input logic             strongMode,
  input logic             done,
  input logic             ack,
  input logic [IDX_W-1:0] vector,
  input logic [LVL_W:0]   pcHigh
);
  a_r5_weak_no_abort: assert property (@(posedge clk) disable iff (rst)
    (!strongMode && pcHigh[LVL_W] && !done) |=> !ack);

  a_r6_strictly_higher: assert property (@(posedge clk) disable iff (rst)
    ack |-> (pcHigh[LVL_W-1:0] > $past(pcHigh[LVL_W-1:0])));

  a_r8_resume_lower: assert property (@(posedge clk) disable iff (rst)
    (done && pcHigh[LVL_W]) |=> (!ack && (pcHigh[LVL_W-1:0] < $past(pcHigh[LVL_W-1:0]))));

  a_r9_kernel_flag: assert property (@(posedge clk) disable iff (rst)
    pcHigh[LVL_W] == (pcHigh[LVL_W-1:0] != '0));

  a_r4_vector_level: assert property (@(posedge clk) disable iff (rst)
    ack |-> (pcHigh[LVL_W-1:0] == LVL_W'(vector) + LVL_W'(1)));
endmodule

bind irq_prio_arb irq_prio_arb_checker #(.NUM_DEV(NUM_DEV), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .strongMode(strongMode), .done(done),
  .ack(ack), .vector(vector), .pcHigh(pcHigh)
);

// File: tb/tb_irq_prio_arb.sv
module tb_irq_prio_arb;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 3;
  localparam int LW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strongMode = 1'b0;
  logic [ND-1:0] req = '0;
  logic          done = 1'b0;
  logic          ack;
  logic [1:0]    vector;
  logic [LW:0]   pcHigh;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  bit pend [ND];
  int stk [$];
  int lvl = 0;
  int mAck = 0;
  int mVec = 0;

  irq_prio_arb #(.NUM_DEV(ND), .LVL_W(LW)) dut (
    .clk(clk), .rst(rst), .strongMode(strongMode), .req(req), .done(done),
    .ack(ack), .vector(vector), .pcHigh(pcHigh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect_eq(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step(logic [ND-1:0] r, logic dn, logic sm, logic rs);
    int best;
    bit popNow, grant;
    if (rs) begin
      for (int d = 0; d < ND; d++) pend[d] = 0;
      stk.delete();
      lvl = 0; mAck = 0; mVec = 0;
      return;
    end
    popNow = dn && (stk.size() > 0);
    best = -1;
    for (int d = 0; d < ND; d++) if (pend[d]) best = d;
    grant = !popNow && (best >= 0) && (best + 1 > lvl) && (sm || stk.size() == 0);
    mAck = grant ? 1 : 0;
    if (popNow) lvl = stk.pop_back();
    if (grant) begin
      stk.push_back(lvl);
      lvl = best + 1;
      mVec = best;
    end
    for (int d = 0; d < ND; d++)
      pend[d] = (pend[d] || r[d]) && !(grant && d == best);
  endtask

  // one clock: drive, take edge, update model, compare away from the edge
  task automatic cyc(logic [ND-1:0] r, logic dn);
    int expPc;
    @(negedge clk);
    req = r; done = dn;
    @(posedge clk);
    model_step(r, dn, strongMode, rst);
    #1;
    expPc = (stk.size() > 0 ? 8 : 0) + lvl;
    expect_eq("R4", "model ack", int'(ack), mAck);
    expect_eq("R4", "model vector", int'(vector), mVec);
    expect_eq("R9", "model pcHigh", int'(pcHigh), expPc);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset with a request held during reset
    rst = 1'b1;
    cyc(3'b001, 0);
    cyc(3'b001, 0);
    rst = 1'b0;
    cyc(3'b000, 0);
    expect_eq("R1", "ack after reset", int'(ack), 0);
    expect_eq("R1", "pcHigh after reset", int'(pcHigh), 0);
    cyc(3'b000, 0);
    expect_eq("R1", "request during reset not served", int'(ack), 0);

    // weak mode: basic grant and no abort
    strongMode = 1'b0;
    cyc(3'b001, 0);
    expect_eq("R4", "ack one edge after sample", int'(ack), 0);
    cyc(3'b000, 0);
    expect_eq("R4", "ack", int'(ack), 1);
    expect_eq("R4", "vector", int'(vector), 0);
    expect_eq("R9", "pcHigh kb", int'(pcHigh), 9);
    cyc(3'b000, 0);
    expect_eq("R4", "ack single cycle", int'(ack), 0);
    cyc(3'b100, 0);
    cyc(3'b000, 0);
    expect_eq("R5", "no preempt in weak", int'(ack), 0);
    expect_eq("R5", "level held in weak", int'(pcHigh), 9);
    cyc(3'b000, 1);
    expect_eq("R8", "done restores user", int'(pcHigh), 0);
    expect_eq("R8", "no grant on done edge", int'(ack), 0);
    cyc(3'b000, 0);
    expect_eq("R5", "pending served after done", int'(ack), 1);
    expect_eq("R5", "disk vector", int'(vector), 2);
    expect_eq("R9", "pcHigh disk", int'(pcHigh), 11);
    cyc(3'b000, 1);

    // R3: simultaneous requests in priority order
    cyc(3'b111, 0);
    cyc(3'b000, 0);
    expect_eq("R3", "highest first", int'(vector), 2);
    cyc(3'b000, 1);
    cyc(3'b000, 0);
    expect_eq("R3", "middle second", int'(vector), 1);
    expect_eq("R3", "pcHigh printer", int'(pcHigh), 10);
    cyc(3'b000, 1);
    cyc(3'b000, 0);
    expect_eq("R3", "lowest last", int'(vector), 0);
    cyc(3'b000, 1);
    expect_eq("R9", "idle pcHigh", int'(pcHigh), 0);

    // strong mode nesting
    strongMode = 1'b1;
    cyc(3'b001, 0);
    cyc(3'b000, 0);
    expect_eq("R6", "kb granted", int'(pcHigh), 9);
    cyc(3'b100, 0);
    cyc(3'b000, 0);
    expect_eq("R6", "disk preempts", int'(ack), 1);
    expect_eq("R6", "disk level", int'(pcHigh), 11);
    cyc(3'b010, 0);
    cyc(3'b000, 0);
    expect_eq("R6", "lower waits", int'(ack), 0);
    cyc(3'b000, 1);
    expect_eq("R8", "resume kb level", int'(pcHigh), 9);
    expect_eq("R8", "no ack at pop", int'(ack), 0);
    cyc(3'b000, 0);
    expect_eq("R8", "printer after pop", int'(ack), 1);
    expect_eq("R6", "printer over kb", int'(pcHigh), 10);
    cyc(3'b000, 1);
    expect_eq("R8", "back to kb", int'(pcHigh), 9);
    cyc(3'b000, 1);
    expect_eq("R9", "kernel bit clear", int'(pcHigh), 0);

    // R7: same level never preempts
    cyc(3'b010, 0);
    cyc(3'b000, 0);
    expect_eq("R7", "printer running", int'(pcHigh), 10);
    cyc(3'b010, 0);
    cyc(3'b000, 0);
    expect_eq("R7", "same level no ack", int'(ack), 0);
    cyc(3'b000, 1);
    cyc(3'b000, 0);
    expect_eq("R7", "served after done", int'(ack), 1);
    expect_eq("R7", "served vector", int'(vector), 1);
    cyc(3'b000, 1);

    // R2: held request and grant-edge absorb
    strongMode = 1'b0;
    cyc(3'b001, 0);
    cyc(3'b000, 0);
    cyc(3'b100, 0);
    cyc(3'b100, 0);
    cyc(3'b100, 0);
    cyc(3'b000, 1);
    cyc(3'b000, 0);
    expect_eq("R2", "held req one grant", int'(vector), 2);
    cyc(3'b000, 1);
    cyc(3'b000, 0);
    expect_eq("R2", "no second grant", int'(ack), 0);
    expect_eq("R2", "idle after", int'(pcHigh), 0);
    cyc(3'b001, 0);
    cyc(3'b001, 0);
    expect_eq("R2", "grant with req high", int'(ack), 1);
    cyc(3'b000, 1);
    cyc(3'b000, 0);
    expect_eq("R2", "absorbed req", int'(ack), 0);

    // R10: done while idle
    cyc(3'b000, 1);
    expect_eq("R10", "idle done pcHigh", int'(pcHigh), 0);
    expect_eq("R10", "idle done ack", int'(ack), 0);
    cyc(3'b100, 1);
    cyc(3'b000, 0);
    expect_eq("R10", "grant unaffected", int'(pcHigh), 11);
    cyc(3'b000, 1);

    // R1: mid-run reset drops pending
    cyc(3'b010, 0);
    rst = 1'b1;
    cyc(3'b000, 0);
    rst = 1'b0;
    cyc(3'b000, 0);
    cyc(3'b000, 0);
    expect_eq("R1", "pending cleared by reset", int'(ack), 0);
    expect_eq("R1", "pcHigh cleared", int'(pcHigh), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule